// File: doc/BRIEF.md
# Round-Robin Slave Arbiter with Parking Policies

This block sits in front of one shared slave and decides which of several masters may access it. Requests are served in rotating order, so every requesting master is reached within a bounded number of grants. When several masters ask at once straight after reset, the lowest-numbered one is served first. Once a master holds the slave, the grant stays put until the slave side signals that the access has ended.

A two-bit policy input decides what happens to the slave connection while nobody is using it. The three choices are:

- **Release:** the connection is dropped.
- **Keep last:** the connection stays with whichever master used the slave last.
- **Fixed:** the connection returns to a master index supplied on a separate input.

A master that already holds the parked connection starts its access with no delay. Any other master first sees a one-cycle latency pulse, during which no grant is driven, and is granted on the following cycle.

Top module: `slave_rr_arbiter`

## Requirements
- R1: During and directly after synchronous reset, `grant_o` is zero and both `connected_o` and `latency_o` are low. The rotation pointer starts at master 0.
- R2: With the pointer at 0 and several masters requesting, the lowest-numbered requester is selected.
- R3: Each selection moves the rotation pointer to the master after the one selected, wrapping at N. The search for the next winner starts at the pointer.
- R4: `grant_o` is zero or one-hot, and it is non-zero exactly when `connected_o` is high.
- R5: While an access is in progress, the grant holds steady whatever the request lines do. Re-arbitration waits for `access_done_i`.
- R6: With policy 0 (release), the cycle after `access_done_i` shows `connected_o` low and no grant. An idle cycle with no request also drops the connection.
- R7: With policy 1 (keep last), the grant to the last master remains after `access_done_i` and through idle cycles. That master's next request is served without a latency pulse.
- R8: With policy 2 (fixed), the cycle after `access_done_i`, and any idle cycle with no request, shows the grant on the master given by `fixed_master_i`. That master's next selection has no latency pulse.
- R9: Selecting a master that does not currently hold the connection raises `latency_o` for one cycle with no grant driven. The grant to that master appears on the next cycle.
- R10: `latency_o` is never high on two consecutive cycles, and the cycle after it always has `connected_o` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | N_MASTERS | Per-master request lines |
| access_done_i | input | 1 | One-cycle pulse marking the end of the current access |
| park_mode_i | input | 2 | Idle policy: 0 release, 1 keep last, 2 fixed (3 behaves as 0) |
| fixed_master_i | input | IDX_W | Master index used by the fixed policy |
| grant_o | output | N_MASTERS | One-hot grant, zero when disconnected |
| connected_o | output | 1 | Slave is connected to some master |
| latency_o | output | 1 | Arbitration latency cycle in progress |

## Verification
All outputs come straight from registers. Every input change is therefore due at the outputs after exactly one rising edge, and a switch to a new master needs two edges: the latency pulse first, then the grant. The bench drives each vector on the falling edge and compares on the next falling edge. A switch thus spans two consecutive rows, the first expecting the pulse and the second the grant. The vector sequence walks the pointer across its wrap point under all three policies, so that rotation order, parking and zero-latency hits are each judged at their exact cycle.

// File: rtl/rrarb_pkg.sv
package rrarb_pkg;

    typedef enum logic [1:0] {
        PARK_NONE  = 2'd0,
        PARK_LAST  = 2'd1,
        PARK_FIXED = 2'd2
    } park_mode_e;

    typedef enum logic [1:0] {
        ST_OPEN   = 2'd0,
        ST_SWITCH = 2'd1,
        ST_BUSY   = 2'd2
    } arb_state_e;

    function automatic park_mode_e decode_mode(input logic [1:0] raw);
        case (raw)
            2'd1:    return PARK_LAST;
            2'd2:    return PARK_FIXED;
            default: return PARK_NONE;
        endcase
    endfunction

endpackage

// File: rtl/rr_pick.sv
module rr_pick #(
    parameter int N_MASTERS = 4,
    localparam int IDX_W = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
    input  logic [N_MASTERS-1:0] req,
    input  logic [IDX_W-1:0]     start,
    output logic                 valid,
    output logic [IDX_W-1:0]     idx
);
    logic [IDX_W-1:0] cand [N_MASTERS];

    // Candidate index at each offset from the start pointer, wrapped at N.
    for (genvar g = 0; g < N_MASTERS; g++) begin : g_cand
        logic [IDX_W:0] sum;
        assign sum = {1'b0, start} + (IDX_W+1)'(g);
        assign cand[g] = (sum >= (IDX_W+1)'(N_MASTERS))
                       ? IDX_W'(sum - (IDX_W+1)'(N_MASTERS))
                       : IDX_W'(sum);
    end

    always_comb begin
        valid = 1'b0;
        idx   = '0;
        for (int i = N_MASTERS - 1; i >= 0; i--) begin
            if (req[cand[i]]) begin
                valid = 1'b1;
                idx   = cand[i];
            end
        end
    end
endmodule

// File: rtl/park_select.sv
module park_select #(
    parameter int N_MASTERS = 4,
    localparam int IDX_W = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
    input  rrarb_pkg::park_mode_e mode,
    input  logic [IDX_W-1:0]      fixed_idx,
    input  logic [IDX_W-1:0]      cur_owner,
    input  logic                  cur_conn,
    output logic [IDX_W-1:0]      nxt_owner,
    output logic                  nxt_conn
);
    import rrarb_pkg::*;

    always_comb begin
        nxt_owner = cur_owner;
        nxt_conn  = cur_conn;
        case (mode)
            PARK_LAST: begin
                nxt_owner = cur_owner;
                nxt_conn  = cur_conn;
            end
            PARK_FIXED: begin
                nxt_owner = fixed_idx;
                nxt_conn  = 1'b1;
            end
            default: begin
                nxt_owner = cur_owner;
                nxt_conn  = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/slave_rr_arbiter.sv
module slave_rr_arbiter #(
    parameter int N_MASTERS = 4,
    localparam int IDX_W = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N_MASTERS-1:0] req_i,
    input  logic                 access_done_i,
    input  logic [1:0]           park_mode_i,
    input  logic [IDX_W-1:0]     fixed_master_i,
    output logic [N_MASTERS-1:0] grant_o,
    output logic                 connected_o,
    output logic                 latency_o
);
    import rrarb_pkg::*;

    arb_state_e       state_q, state_d;
    logic [IDX_W-1:0] owner_q, owner_d;
    logic [IDX_W-1:0] target_q, target_d;
    logic [IDX_W-1:0] ptr_q, ptr_d;
    logic             conn_q, conn_d;

    logic             pick_valid;
    logic [IDX_W-1:0] pick_idx;
    logic [IDX_W-1:0] park_owner;
    logic             park_conn;
    logic [IDX_W-1:0] ptr_after_pick;
    park_mode_e       mode;

    assign mode = decode_mode(park_mode_i);

    rr_pick #(.N_MASTERS(N_MASTERS)) u_pick (
        .req   (req_i),
        .start (ptr_q),
        .valid (pick_valid),
        .idx   (pick_idx)
    );

    park_select #(.N_MASTERS(N_MASTERS)) u_park (
        .mode      (mode),
        .fixed_idx (fixed_master_i),
        .cur_owner (owner_q),
        .cur_conn  (conn_q),
        .nxt_owner (park_owner),
        .nxt_conn  (park_conn)
    );

    assign ptr_after_pick = (pick_idx == IDX_W'(N_MASTERS - 1)) ? '0 : pick_idx + 1'b1;

    always_comb begin
        state_d  = state_q;
        owner_d  = owner_q;
        conn_d   = conn_q;
        ptr_d    = ptr_q;
        target_d = target_q;
        case (state_q)
            ST_OPEN: begin
                if (pick_valid) begin
                    ptr_d = ptr_after_pick;
                    if (conn_q && (pick_idx == owner_q)) begin
                        state_d = ST_BUSY;
                    end else begin
                        state_d  = ST_SWITCH;
                        conn_d   = 1'b0;
                        target_d = pick_idx;
                    end
                end else begin
                    owner_d = park_owner;
                    conn_d  = park_conn;
                end
            end
            ST_SWITCH: begin
                state_d = ST_BUSY;
                owner_d = target_q;
                conn_d  = 1'b1;
            end
            ST_BUSY: begin
                if (access_done_i) begin
                    state_d = ST_OPEN;
                    owner_d = park_owner;
                    conn_d  = park_conn;
                end
            end
            default: begin
                state_d = ST_OPEN;
                conn_d  = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_OPEN;
            owner_q  <= '0;
            target_q <= '0;
            ptr_q    <= '0;
            conn_q   <= 1'b0;
        end else begin
            state_q  <= state_d;
            owner_q  <= owner_d;
            target_q <= target_d;
            ptr_q    <= ptr_d;
            conn_q   <= conn_d;
        end
    end

    always_comb begin
        grant_o = '0;
        if (conn_q) grant_o[owner_q] = 1'b1;
    end

    assign connected_o = conn_q;
    assign latency_o   = (state_q == ST_SWITCH);
endmodule

// File: rtl/slave_rr_arbiter_chk.sv
module slave_rr_arbiter_chk #(
    parameter int N_MASTERS = 4,
    localparam int IDX_W = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 busy,
    input logic                 access_done_i,
    input logic [1:0]           park_mode_i,
    input logic [IDX_W-1:0]     fixed_master_i,
    input logic [N_MASTERS-1:0] grant_o,
    input logic                 connected_o,
    input logic                 latency_o
);
    // R4
    grant_shape_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_o) && ((|grant_o) == connected_o));

    // R5
    grant_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !access_done_i) |=> $stable(grant_o) && connected_o);

    // R6
    release_park_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && access_done_i && park_mode_i == 2'd0) |=> !connected_o);

    // R7
    keep_last_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && access_done_i && park_mode_i == 2'd1) |=> $stable(grant_o) && connected_o);

    // R8
    fixed_park_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && access_done_i && park_mode_i == 2'd2)
        |=> connected_o && grant_o[$past(fixed_master_i)]);

    // R9
    latency_nogrant_chk: assert property (@(posedge clk) disable iff (rst)
        latency_o |-> !connected_o);

    // R10
    latency_single_chk: assert property (@(posedge clk) disable iff (rst)
        latency_o |=> !latency_o && connected_o);
endmodule

bind slave_rr_arbiter slave_rr_arbiter_chk #(.N_MASTERS(N_MASTERS)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .busy           (state_q == rrarb_pkg::ST_BUSY),
    .access_done_i  (access_done_i),
    .park_mode_i    (park_mode_i),
    .fixed_master_i (fixed_master_i),
    .grant_o        (grant_o),
    .connected_o    (connected_o),
    .latency_o      (latency_o)
);

// File: tb/tb_slave_rr_arbiter.sv
module tb_slave_rr_arbiter;
    localparam int N = 4;
    localparam int IW = 2;
    localparam int NV = 25;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  req = '0;
    logic          done = 1'b0;
    logic [1:0]    mode = 2'd0;
    logic [IW-1:0] fixed = '0;
    logic [N-1:0]  grant;
    logic          conn;
    logic          lat;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    slave_rr_arbiter #(.N_MASTERS(N)) dut (
        .clk            (clk),
        .rst            (rst),
        .req_i          (req),
        .access_done_i  (done),
        .park_mode_i    (mode),
        .fixed_master_i (fixed),
        .grant_o        (grant),
        .connected_o    (conn),
        .latency_o      (lat)
    );

    // {req, done, mode, fixed, exp_grant, exp_conn, exp_lat}
    localparam logic [14:0] VEC [NV] = '{
        {4'b0110, 1'b0, 2'd0, 2'd0, 4'b0000, 1'b0, 1'b1}, // R2 R9: lowest requester m1, latency
        {4'b0110, 1'b0, 2'd0, 2'd0, 4'b0010, 1'b1, 1'b0}, // R9 grant after pulse
        {4'b0110, 1'b0, 2'd0, 2'd0, 4'b0010, 1'b1, 1'b0}, // R5 hold
        {4'b0100, 1'b1, 2'd0, 2'd0, 4'b0000, 1'b0, 1'b0}, // R6 release
        {4'b0100, 1'b0, 2'd0, 2'd0, 4'b0000, 1'b0, 1'b1}, // R3 ptr at m2
        {4'b0100, 1'b0, 2'd0, 2'd0, 4'b0100, 1'b1, 1'b0}, // R9
        {4'b0000, 1'b1, 2'd1, 2'd0, 4'b0100, 1'b1, 1'b0}, // R7 keep last
        {4'b0000, 1'b0, 2'd1, 2'd0, 4'b0100, 1'b1, 1'b0}, // R7 idle keep
        {4'b0100, 1'b0, 2'd1, 2'd0, 4'b0100, 1'b1, 1'b0}, // R7 no latency
        {4'b0001, 1'b1, 2'd1, 2'd0, 4'b0100, 1'b1, 1'b0}, // R5 R7
        {4'b0001, 1'b0, 2'd1, 2'd0, 4'b0000, 1'b0, 1'b1}, // R9 wrap to m0
        {4'b0001, 1'b0, 2'd1, 2'd0, 4'b0001, 1'b1, 1'b0}, // R3
        {4'b0000, 1'b1, 2'd2, 2'd3, 4'b1000, 1'b1, 1'b0}, // R8 park on m3
        {4'b1000, 1'b0, 2'd2, 2'd3, 4'b1000, 1'b1, 1'b0}, // R8 no latency
        {4'b0010, 1'b1, 2'd2, 2'd3, 4'b1000, 1'b1, 1'b0}, // R8
        {4'b0010, 1'b0, 2'd2, 2'd3, 4'b0000, 1'b0, 1'b1}, // R9 non-parked
        {4'b0010, 1'b0, 2'd2, 2'd3, 4'b0010, 1'b1, 1'b0}, // R10
        {4'b1111, 1'b1, 2'd2, 2'd3, 4'b1000, 1'b1, 1'b0}, // R8
        {4'b1111, 1'b0, 2'd2, 2'd3, 4'b0000, 1'b0, 1'b1}, // R3 ptr m2
        {4'b1111, 1'b0, 2'd2, 2'd3, 4'b0100, 1'b1, 1'b0}, // R3
        {4'b1111, 1'b1, 2'd2, 2'd3, 4'b1000, 1'b1, 1'b0}, // R8
        {4'b1111, 1'b0, 2'd2, 2'd3, 4'b1000, 1'b1, 1'b0}, // R3 m3 parked hit
        {4'b1111, 1'b1, 2'd0, 2'd3, 4'b0000, 1'b0, 1'b0}, // R6
        {4'b1111, 1'b0, 2'd0, 2'd3, 4'b0000, 1'b0, 1'b1}, // R3 wrap to m0
        {4'b1111, 1'b0, 2'd0, 2'd3, 4'b0001, 1'b1, 1'b0}  // R10
    };

    task automatic check(input string tag, input logic [5:0] act, input logic [5:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got grant/conn/lat=%b expected %b", tag, act, exp);
        end
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        check("R1 reset", {grant, conn, lat}, 6'b0000_0_0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset", {grant, conn, lat}, 6'b0000_0_0);

        for (int i = 0; i < NV; i++) begin
            {req, done, mode, fixed} = VEC[i][14:6];
            @(negedge clk);
            check($sformatf("vector row %0d (see row tag)", i),
                  {grant, conn, lat}, VEC[i][5:0]);
        end

        // R1: reset mid-access clears everything
        rst = 1'b1; req = '0; done = 1'b0; mode = 2'd2; fixed = 2'd2;
        @(negedge clk);
        check("R1 mid-run reset", {grant, conn, lat}, 6'b0000_0_0);
        rst = 1'b0;
        // R8: idle with fixed policy parks on fixed master
        @(negedge clk);
        check("R8 idle park", {grant, conn, lat}, 6'b0100_1_0);
        // R2: pointer reset to 0, m2 parked, m0 and m2 request: m0 wins
        req = 4'b0101;
        @(negedge clk);
        check("R2 lowest after reset", {grant, conn, lat}, 6'b0000_0_1);
        @(negedge clk);
        check("R2 grant m0", {grant, conn, lat}, 6'b0001_1_0);
        // R5: requests vanish, grant held
        req = 4'b0000;
        repeat (3) @(negedge clk);
        check("R5 hold without request", {grant, conn, lat}, 6'b0001_1_0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule